// File: doc/BRIEF.md
# Oscillator-to-PLL Clock Source Sequencer

This block holds the clock configuration of a chip: a control register that selects bypass, the PLL power state, a crystal frequency code, an oscillator source and a 7-bit system divider, and a status word that carries a latched PLL-lock flag and a configuration-error flag. The analog PLL is replaced by a lock model. Once power-down is cleared, the lock flag rises after a programmable number of reference cycles. Setting power-down again drops the flag in the same edge.

The block produces a clock-enable stream that stands in for the system clock. In bypass the enable is high every cycle, which is the oscillator clock with no divider. In PLL mode it pulses once every divider+1 cycles. Software clears bypass to move onto the PLL. That request is refused until the lock flag is already set, so the design stays on the oscillator. Changes of source and of divider take effect only at the end of a divider period, so no short pulse ever appears.

Top module: `clkseq_top`

## Requirements
- R1: After reset the control register reads 0x002A2800 (bypass bit 11 = 1, power-down bit 13 = 1, crystal code 0x15 in bits 21:17, divider 0, source 0), the status word reads 0, `pllSel` is 0 and `clkEn` is 1.
- R2: A control write stores only bypass (bit 11), power-down (bit 13), divider (bits 28:22), crystal code (bits 21:17) and oscillator source (bits 6:4). Every other bit reads 0, so writing all ones in bypass with power-down reads back 0x1FFE2870.
- R3: The lock flag (status bit 6) reads 0 for LOCK_DELAY-1 cycles after the write that clears power-down, and reads 1 after exactly LOCK_DELAY cycles.
- R4: A write that sets power-down clears the lock flag on that same edge and forces bypass to 1. The enable then returns to the every-cycle pattern once the current divider period ends.
- R5: A write that clears bypass is refused, and bit 11 still reads 1, when the lock flag was 0 before the write edge or when the same write sets power-down. This holds even when the lock flag rises on that very edge. A refused request leaves `pllSel` at 0.
- R6: While the active source is the oscillator (`pllSel` = 0), `clkEn` is 1 in every cycle.
- R7: With bypass accepted, `pllSel` is 1 and `clkEn` pulses for exactly one cycle in every divider+1 cycles, for any divider value from 0 to 127.
- R8: A new divider or source takes effect only after the pulse that ends the current period. A divider change written in mid-period leaves that period at its old length.
- R9: Status bit 0 (configuration error) is 1 exactly when the crystal code is 0x00 to 0x03 or 0x1B to 0x1F.
- R10: `mainOsc` is 1 exactly when the oscillator source field is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Control register write strobe |
| wrData | input | 32 | Control register write value |
| ctrlRd | output | 32 | Control register contents |
| statusRd | output | 32 | Status word: bit 6 lock, bit 0 configuration error |
| clkEn | output | 1 | System clock enable pulse |
| pllSel | output | 1 | Active source is the divided PLL |
| mainOsc | output | 1 | Oscillator source field selects the main oscillator |

## Verification
Two events can land on the same edge: the lock flag rising at the end of its count, and a software write that clears bypass. The bench times such a write to hit exactly the LOCK_DELAY-th edge after power-up. It then expects the request to be refused, because acceptance uses the lock value held before the edge, while the lock bit reads 1 afterwards. A second collision comes from a divider rewrite in the middle of a PLL period. The bench counts the cycles between pulses and expects the old length first and the new length after it.

// File: rtl/clkseq_pkg.sv
package clkseq_pkg;
  localparam int BYP_BIT   = 11;
  localparam int PDN_BIT   = 13;
  localparam int DIV_LSB   = 22;
  localparam int DIV_W     = 7;
  localparam int XTAL_LSB  = 17;
  localparam int XTAL_W    = 5;
  localparam int OSC_LSB   = 4;
  localparam int OSC_W     = 3;
  localparam int LOCK_BIT  = 6;
  localparam int ERR_BIT   = 0;
  localparam logic [31:0] CTRL_MASK = 32'h1FFE_2870;
  localparam logic [31:0] CTRL_RST  = 32'h002A_2800;
  localparam logic [XTAL_W-1:0] XTAL_LO_OK = 5'h04;
  localparam logic [XTAL_W-1:0] XTAL_HI_OK = 5'h1A;

  typedef struct packed {
    logic             reqPll;
    logic [DIV_W-1:0] div;
  } seqStrobe_t;
endpackage

// File: rtl/clkseq_ctrl.sv
module clkseq_ctrl
  import clkseq_pkg::*;
#(
  parameter int LOCK_DELAY = 12
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        wrEn,
  input  logic [31:0] wrData,
  output logic [31:0] ctrlQ,
  output logic        lockQ,
  output logic        cfgErr,
  output logic        mainOsc,
  output seqStrobe_t  strb
);
  localparam int CNTW = $clog2(LOCK_DELAY) + 1;
  localparam logic [CNTW-1:0] CNT_LAST = CNTW'(LOCK_DELAY - 1);

  logic [CNTW-1:0]   lockCnt;
  logic              pdnQ, pdnNext, runGranted;
  logic [XTAL_W-1:0] xtalCode;

  assign pdnQ       = ctrlQ[PDN_BIT];
  assign pdnNext    = wrEn ? wrData[PDN_BIT] : pdnQ;
  assign runGranted = !wrData[BYP_BIT] && lockQ && !wrData[PDN_BIT];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlQ <= CTRL_RST;
    end else if (wrEn) begin
      ctrlQ          <= wrData & CTRL_MASK;
      ctrlQ[BYP_BIT] <= !runGranted;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lockQ   <= 1'b0;
      lockCnt <= '0;
    end else if (pdnNext || pdnQ) begin
      lockQ   <= 1'b0;
      lockCnt <= '0;
    end else if (!lockQ) begin
      if (lockCnt == CNT_LAST) lockQ <= 1'b1;
      else                     lockCnt <= lockCnt + 1'b1;
    end
  end

  assign xtalCode    = ctrlQ[XTAL_LSB +: XTAL_W];
  assign cfgErr      = (xtalCode < XTAL_LO_OK) || (xtalCode > XTAL_HI_OK);
  assign mainOsc     = (ctrlQ[OSC_LSB +: OSC_W] == '0);
  assign strb.reqPll = !ctrlQ[BYP_BIT];
  assign strb.div    = ctrlQ[DIV_LSB +: DIV_W];

  assert_bypass_needs_lock_R5: assert property (@(posedge clk) disable iff (!rstN)
    $fell(ctrlQ[BYP_BIT]) |-> $past(lockQ));
  assert_pdn_kills_lock_R4: assert property (@(posedge clk) disable iff (!rstN)
    pdnQ |-> !lockQ);
  assert_lock_after_run_R3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(lockQ) |-> (!pdnQ && $past(!pdnQ)));
endmodule

// File: rtl/clkseq_datapath.sv
module clkseq_datapath
  import clkseq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  seqStrobe_t strb,
  output logic       clkEn,
  output logic       pllSel
);
  logic             selQ;
  logic [DIV_W-1:0] divCnt, divLat;
  logic             boundary;

  assign boundary = selQ && (divCnt == divLat);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      selQ   <= 1'b0;
      divLat <= '0;
      divCnt <= '0;
    end else if (!selQ || boundary) begin
      selQ   <= strb.reqPll;
      divLat <= strb.div;
      divCnt <= '0;
    end else begin
      divCnt <= divCnt + 1'b1;
    end
  end

  assign clkEn  = !selQ || boundary;
  assign pllSel = selQ;

  assert_switch_on_boundary_R8: assert property (@(posedge clk) disable iff (!rstN)
    (selQ != $past(selQ)) |-> ($past(!selQ) || $past(divCnt == divLat)));
  assert_count_in_range_R7: assert property (@(posedge clk) disable iff (!rstN)
    selQ |-> (divCnt <= divLat));
endmodule

// File: rtl/clkseq_top.sv
module clkseq_top
  import clkseq_pkg::*;
#(
  parameter int LOCK_DELAY = 12
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        wrEn,
  input  logic [31:0] wrData,
  output logic [31:0] ctrlRd,
  output logic [31:0] statusRd,
  output logic        clkEn,
  output logic        pllSel,
  output logic        mainOsc
);
  seqStrobe_t strb;
  logic       lockQ, cfgErr;

  clkseq_ctrl #(.LOCK_DELAY(LOCK_DELAY)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData),
    .ctrlQ(ctrlRd), .lockQ(lockQ), .cfgErr(cfgErr), .mainOsc(mainOsc),
    .strb(strb)
  );

  clkseq_datapath u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .clkEn(clkEn), .pllSel(pllSel)
  );

  always_comb begin
    statusRd           = '0;
    statusRd[LOCK_BIT] = lockQ;
    statusRd[ERR_BIT]  = cfgErr;
  end
endmodule

// File: tb/sim_clkseq_top.sv
module sim_clkseq_top;
  localparam int CLK_PERIOD = 10;
  localparam int LOCK_CYC   = 12;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [31:0] wrData = '0;
  logic [31:0] ctrlRd, statusRd;
  logic        clkEn, pllSel, mainOsc;
  int          nChecks = 0;
  int          nFails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  clkseq_top #(.LOCK_DELAY(LOCK_CYC)) u0 (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData),
    .ctrlRd(ctrlRd), .statusRd(statusRd), .clkEn(clkEn),
    .pllSel(pllSel), .mainOsc(mainOsc)
  );

  function automatic logic [31:0] mk(bit byp, bit pdn, int div, int osc, int xtal);
    logic [31:0] v = '0;
    v[11] = byp; v[13] = pdn;
    v[28:22] = 7'(div); v[21:17] = 5'(xtal); v[6:4] = 3'(osc);
    return v;
  endfunction

  task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  // called at a falling edge; the write lands on the next rising edge
  task automatic writeCtrl(logic [31:0] d);
    wrEn = 1'b1; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic measure(int exp, string tag);
    int c = 0;
    while (!clkEn && c < 300) begin @(negedge clk); c++; end
    c = 0;
    do begin @(negedge clk); c++; end while (!clkEn && c < 300);
    check(c == exp, tag, c, exp);
    check(pllSel == 1'b1, tag, pllSel, 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nChecks++; nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(ctrlRd == 32'h002A2800, "R1 ctrl", ctrlRd, 32'h002A2800);
    check(statusRd == 32'h0, "R1 status", statusRd, 0);
    check(pllSel == 1'b0 && clkEn == 1'b1, "R1 outputs", {pllSel, clkEn}, 2'b01);

    // R2 field layout
    writeCtrl(32'hFFFF_FFFF);
    check(ctrlRd == 32'h1FFE2870, "R2 mask", ctrlRd, 32'h1FFE2870);

    // R9 crystal code sweep
    for (int x = 0; x < 32; x++) begin
      writeCtrl(mk(1, 1, 0, 0, x));
      check(statusRd[0] == ((x < 4) || (x > 26)), "R9 cfgErr", statusRd[0], (x < 4) || (x > 26));
    end

    // R10 source sweep
    for (int s = 0; s < 8; s++) begin
      writeCtrl(mk(1, 1, 3, s, 5'h15));
      check(mainOsc == (s == 0), "R10 mainOsc", mainOsc, s == 0);
      check(ctrlRd[6:4] == 3'(s), "R2 osc field", ctrlRd[6:4], s);
    end

    // R6 bypass: enable each cycle despite divider
    writeCtrl(mk(1, 1, 4, 0, 5'h15));
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      check(clkEn == 1'b1 && pllSel == 1'b0, "R6 bypass enable", {pllSel, clkEn}, 2'b01);
    end

    // R5 refused while unlocked
    writeCtrl(mk(0, 1, 4, 0, 5'h15));
    check(ctrlRd[11] == 1'b1, "R5 bypass held", ctrlRd[11], 1);
    repeat (3) @(negedge clk);
    check(pllSel == 1'b0 && clkEn == 1'b1, "R5 stay on osc", {pllSel, clkEn}, 2'b01);

    // R3 lock timing, with a bypass-clear write on the lock edge (R5)
    writeCtrl(mk(1, 0, 4, 0, 5'h15));
    repeat (LOCK_CYC - 1) @(negedge clk);
    check(statusRd[6] == 1'b0, "R3 lock early", statusRd[6], 0);
    writeCtrl(mk(0, 0, 4, 0, 5'h15));
    check(statusRd[6] == 1'b1, "R3 lock on time", statusRd[6], 1);
    check(ctrlRd[11] == 1'b1, "R5 same-edge refusal", ctrlRd[11], 1);
    @(negedge clk);
    check(pllSel == 1'b0, "R5 same-edge no switch", pllSel, 0);

    // R7 accepted switch and divider sweep
    writeCtrl(mk(0, 0, 4, 0, 5'h15));
    check(ctrlRd[11] == 1'b0, "R7 bypass accepted", ctrlRd[11], 0);
    for (int n = 0; n < 9; n++) begin
      int dv = (n == 8) ? 127 : n;
      writeCtrl(mk(0, 0, dv, 0, 5'h15));
      measure(dv + 1, "R7 period");
      measure(dv + 1, "R7 period repeat");
    end

    // R8 mid-period divider change keeps old length
    writeCtrl(mk(0, 0, 7, 0, 5'h15));
    measure(8, "R8 setup");
    begin
      int c = 4;
      repeat (3) @(negedge clk);
      writeCtrl(mk(0, 0, 1, 0, 5'h15));
      while (!clkEn && c < 300) begin @(negedge clk); c++; end
      check(c == 8, "R8 old period kept", c, 8);
    end
    measure(2, "R8 new period");

    // R4 power-down while on PLL
    writeCtrl(mk(0, 1, 1, 0, 5'h15));
    check(statusRd[6] == 1'b0, "R4 lock cleared", statusRd[6], 0);
    check(ctrlRd[11] == 1'b1, "R4 bypass forced", ctrlRd[11], 1);
    repeat (3) @(negedge clk);
    for (int i = 0; i < 4; i++) begin
      check(pllSel == 1'b0 && clkEn == 1'b1, "R4 back on osc", {pllSel, clkEn}, 2'b01);
      @(negedge clk);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule